// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Controller

This block finds the best receive sampling delay for a high-speed SD data interface. After a start pulse it tries every tap of an external delay line in rising order. For each tap it loads the tap into the delay line and asks a command engine to send the tuning command. It then compares the tuning block that returns on the data lines, byte by byte as the bytes arrive, with a pattern built inside the block. A tap passes only when the whole block matches and the command engine reports no fault.

The block does not store a pass map. It keeps the longest unbroken run of passing taps as it goes. When the sweep ends it loads the middle tap of that run into the delay line. It also drives that tap to the command sampling path, because the command and data inputs have matched buffering and delay. A sweep with no passing tap raises an error flag and leaves both delay outputs at zero. The command engine, the CRC logic and the delay line sit outside this block. They connect through a one-cycle request, a one-cycle completion strobe with a fault bit, and a byte stream with a valid qualifier.

Top module: `tune_dly_sweeper`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `err_o`, `cmd_req_o` and `dly_load_o` are 0, and `dly_tap_o` and `cmd_dly_o` are 0.
- R2: A `start_i` pulse taken while idle or done begins a sweep of taps 0 to 127 in rising order. Each trial raises `dly_load_o` for one cycle while `dly_tap_o` shows the new tap. In the next cycle `cmd_req_o` pulses for one cycle. `dly_tap_o` changes only in a cycle where `dly_load_o` is high.
- R3: A trial passes when three things hold at the `cmd_done_i` strobe. Exactly 64 bytes arrived after the request and before that strobe. Byte i equals ((i*37) mod 256) XOR 0xA5. `cmd_err_i` is low with the strobe.
- R4: A trial fails, and the sweep goes on to the next tap, in four cases: a byte mismatch, fewer than 64 bytes, more than 64 bytes, or `cmd_err_i` high with the strobe even when the data was correct.
- R5: The chosen run is the longest run of consecutive passing taps. When two runs have the same length, the one with the lower taps wins.
- R6: The chosen tap is run start + floor((run length - 1) / 2). A run that reaches tap 127 is counted.
- R7: If no tap passes, `err_o` is 1 and `dly_tap_o` and `cmd_dly_o` are 0 at completion, and `done_o` is still raised.
- R8: At completion `dly_load_o` pulses with `dly_tap_o` set to the chosen tap. From then on `cmd_dly_o` equals `dly_tap_o`. During a sweep `cmd_dly_o` keeps the result of the previous sweep.
- R9: `done_o` stays high until the next accepted start. A `start_i` pulse during a sweep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a tuning sweep |
| dly_tap_o | output | 7 | Tap value for the data-path delay line |
| dly_load_o | output | 1 | Load strobe for the delay line |
| cmd_req_o | output | 1 | Request to send one tuning command |
| cmd_done_i | input | 1 | Tuning command finished (one-cycle strobe) |
| cmd_err_i | input | 1 | Timeout or CRC fault, valid with `cmd_done_i` |
| rx_valid_i | input | 1 | Received data byte valid |
| rx_data_i | input | 8 | Received data byte |
| cmd_dly_o | output | 7 | Tap value applied to the command sampling path |
| done_o | output | 1 | Sweep complete |
| err_o | output | 1 | No passing tap was found |

## Verification
The bench sets a pass or fail outcome for every tap and computes the midpoint in its own model.

**Window shapes.** The directed sweeps cover:
- two equal-length windows, where a design that replaced the best run on equal length would pick the later window;
- a window that runs up to tap 127, where a tracker that updated only when a run ends would miss it;
- an even-length window, where rounding up would move the result by one;
- a single pass at tap 0;
- a sweep with no passing tap, where a design could report a bogus tap or never raise done.

**Failure kinds.** Each failure kind is used on its own to bound a window:
- a byte mismatch;
- a short block;
- a long block;
- a command fault on a correct block.

A comparator that ignored the byte count or the fault bit would widen the window and shift the midpoint.

**Stray start.** A start pulse in the middle of a sweep checks that a restart would break the rising tap order.

// File: rtl/tune_pkg.sv
package tune_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_ISSUE,
      ST_WAIT,
      ST_FIN,
      ST_APPLY,
      ST_DONE
   } tune_st_e;

   // Default pattern: index times 37, low byte, XOR 0xA5.
   function automatic logic [7:0] pat_mulxor(input int idx);
      logic [31:0] p;
      p = 32'(idx) * 32'd37;
      return p[7:0] ^ 8'hA5;
   endfunction

   // Alternate pattern: inverted low byte of index times 3.
   function automatic logic [7:0] pat_inv(input int idx);
      logic [31:0] p;
      p = 32'(idx) * 32'd3;
      return ~p[7:0];
   endfunction

endpackage

// File: rtl/tune_blk_cmp.sv
module tune_blk_cmp #(
   parameter int BLK_BYTES = 64,
   parameter int PAT_KIND  = 0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       clr_i,
   input  logic       en_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_data_i,
   output logic       pass_o
);

   localparam int CNT_W = $clog2(BLK_BYTES + 1);
   localparam int IDX_W = $clog2(BLK_BYTES);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BLK_BYTES);

   logic [7:0]       rom [BLK_BYTES];
   logic [CNT_W-1:0] cnt_q;
   logic             bad_q;
   logic [7:0]       exp_byte;

   // Reference pattern table, one variant picked by parameter
   generate
      if (PAT_KIND == 0) begin : g_mulxor
         for (genvar g = 0; g < BLK_BYTES; g++) begin : g_ent
            assign rom[g] = tune_pkg::pat_mulxor(g);
         end
      end else begin : g_inv
         for (genvar g = 0; g < BLK_BYTES; g++) begin : g_ent
            assign rom[g] = tune_pkg::pat_inv(g);
         end
      end
   endgenerate

   assign exp_byte = rom[cnt_q[IDX_W-1:0]];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         bad_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         bad_q <= 1'b0;
      end else if (en_i && rx_valid_i) begin
         if (cnt_q == FULL) begin
            bad_q <= 1'b1;             // block longer than expected
         end else begin
            if (rx_data_i != exp_byte) bad_q <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pass_o = !bad_q && (cnt_q == FULL);

endmodule

// File: rtl/tune_run_track.sv
module tune_run_track #(
   parameter int TAP_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             res_valid_i,
   input  logic             res_pass_i,
   input  logic [TAP_W-1:0] res_tap_i,
   input  logic             last_i,
   output logic [TAP_W-1:0] mid_o,
   output logic             none_o
);

   localparam int LEN_W = TAP_W + 1;

   logic [LEN_W-1:0] cur_len_q, best_len_q;
   logic [TAP_W-1:0] cur_start_q, best_start_q;
   logic [LEN_W-1:0] run_len_nx, cand_len, half_len;
   logic [TAP_W-1:0] run_start_nx, cand_start;
   logic             take;

   always_comb begin
      run_len_nx   = res_pass_i ? cur_len_q + 1'b1 : '0;
      run_start_nx = (res_pass_i && cur_len_q == '0) ? res_tap_i : cur_start_q;
      cand_len     = res_pass_i ? run_len_nx   : cur_len_q;
      cand_start   = res_pass_i ? run_start_nx : cur_start_q;
      // strictly longer replaces: equal length keeps the earlier run
      take         = (!res_pass_i || last_i) && (cand_len > best_len_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_len_q    <= '0;
         cur_start_q  <= '0;
         best_len_q   <= '0;
         best_start_q <= '0;
      end else if (clr_i) begin
         cur_len_q    <= '0;
         cur_start_q  <= '0;
         best_len_q   <= '0;
         best_start_q <= '0;
      end else if (res_valid_i) begin
         cur_len_q   <= run_len_nx;
         cur_start_q <= run_start_nx;
         if (take) begin
            best_len_q   <= cand_len;
            best_start_q <= cand_start;
         end
      end
   end

   assign half_len = (best_len_q - 1'b1) >> 1;
   assign mid_o    = best_start_q + half_len[TAP_W-1:0];
   assign none_o   = (best_len_q == '0);

endmodule

// File: rtl/tune_seq.sv
module tune_seq #(
   parameter int TAP_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             cmd_done_i,
   input  logic             cmd_err_i,
   input  logic             blk_pass_i,
   input  logic [TAP_W-1:0] mid_i,
   input  logic             none_i,
   output logic [TAP_W-1:0] dly_tap_o,
   output logic             dly_load_o,
   output logic             cmd_req_o,
   output logic [TAP_W-1:0] cmd_dly_o,
   output logic             done_o,
   output logic             err_o,
   output logic             cmp_clr_o,
   output logic             cmp_en_o,
   output logic             trk_clr_o,
   output logic             res_valid_o,
   output logic             res_pass_o,
   output logic             last_o
);

   import tune_pkg::*;

   tune_st_e         st_q;
   logic [TAP_W-1:0] tap_q, cmd_q;
   logic             err_q;
   logic             accept;
   logic [TAP_W-1:0] final_tap;

   assign accept    = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
   assign last_o    = (tap_q == {TAP_W{1'b1}});
   assign final_tap = none_i ? '0 : mid_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         tap_q <= '0;
         cmd_q <= '0;
         err_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  st_q  <= ST_PROG;
                  tap_q <= '0;
                  err_q <= 1'b0;
               end
            end
            ST_PROG:  st_q <= ST_ISSUE;
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (cmd_done_i) begin
                  if (last_o) begin
                     st_q <= ST_FIN;
                  end else begin
                     tap_q <= tap_q + 1'b1;
                     st_q  <= ST_PROG;
                  end
               end
            end
            ST_FIN: begin
               st_q  <= ST_APPLY;
               tap_q <= final_tap;
               cmd_q <= final_tap;
               err_q <= none_i;
            end
            ST_APPLY: st_q <= ST_DONE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign dly_tap_o   = tap_q;
   assign dly_load_o  = (st_q == ST_PROG) || (st_q == ST_APPLY);
   assign cmd_req_o   = (st_q == ST_ISSUE);
   assign cmd_dly_o   = cmd_q;
   assign done_o      = (st_q == ST_DONE);
   assign err_o       = err_q;
   assign cmp_clr_o   = (st_q == ST_PROG);
   assign cmp_en_o    = (st_q == ST_WAIT);
   assign trk_clr_o   = accept;
   assign res_valid_o = (st_q == ST_WAIT) && cmd_done_i;
   assign res_pass_o  = blk_pass_i && !cmd_err_i;

endmodule

// File: rtl/tune_dly_sweeper.sv
module tune_dly_sweeper #(
   parameter int TAP_W     = 7,
   parameter int BLK_BYTES = 64,
   parameter int PAT_KIND  = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic [TAP_W-1:0] dly_tap_o,
   output logic             dly_load_o,
   output logic             cmd_req_o,
   input  logic             cmd_done_i,
   input  logic             cmd_err_i,
   input  logic             rx_valid_i,
   input  logic [7:0]       rx_data_i,
   output logic [TAP_W-1:0] cmd_dly_o,
   output logic             done_o,
   output logic             err_o
);

   // Elaboration-time parameter checks
   generate
      if (TAP_W < 2 || TAP_W > 10) begin : g_bad_tap_w
         $error("tune_dly_sweeper: TAP_W must lie in 2..10");
      end
      if (BLK_BYTES < 2 || BLK_BYTES > 512) begin : g_bad_blk
         $error("tune_dly_sweeper: BLK_BYTES must lie in 2..512");
      end
      if (PAT_KIND < 0 || PAT_KIND > 1) begin : g_bad_kind
         $error("tune_dly_sweeper: PAT_KIND must be 0 or 1");
      end
   endgenerate

   logic             blk_pass, cmp_clr, cmp_en;
   logic             trk_clr, res_valid, res_pass, last_tap, none;
   logic [TAP_W-1:0] mid;

   tune_blk_cmp #(
      .BLK_BYTES (BLK_BYTES),
      .PAT_KIND  (PAT_KIND)
   ) u_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (cmp_clr),
      .en_i       (cmp_en),
      .rx_valid_i (rx_valid_i),
      .rx_data_i  (rx_data_i),
      .pass_o     (blk_pass)
   );

   tune_run_track #(
      .TAP_W (TAP_W)
   ) u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (trk_clr),
      .res_valid_i (res_valid),
      .res_pass_i  (res_pass),
      .res_tap_i   (dly_tap_o),
      .last_i      (last_tap),
      .mid_o       (mid),
      .none_o      (none)
   );

   tune_seq #(
      .TAP_W (TAP_W)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .cmd_done_i  (cmd_done_i),
      .cmd_err_i   (cmd_err_i),
      .blk_pass_i  (blk_pass),
      .mid_i       (mid),
      .none_i      (none),
      .dly_tap_o   (dly_tap_o),
      .dly_load_o  (dly_load_o),
      .cmd_req_o   (cmd_req_o),
      .cmd_dly_o   (cmd_dly_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .cmp_clr_o   (cmp_clr),
      .cmp_en_o    (cmp_en),
      .trk_clr_o   (trk_clr),
      .res_valid_o (res_valid),
      .res_pass_o  (res_pass),
      .last_o      (last_tap)
   );

endmodule

// File: rtl/tune_dly_sweeper_chk.sv
module tune_dly_sweeper_chk #(
   parameter int TAP_W = 7
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [TAP_W-1:0] dly_tap_o,
   input logic             dly_load_o,
   input logic             cmd_req_o,
   input logic [TAP_W-1:0] cmd_dly_o,
   input logic             done_o,
   input logic             err_o
);

   // R2: a request follows a delay-line load
   p_load_then_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_req_o |-> $past(dly_load_o));

   // R2: the request lasts one cycle
   p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_req_o |=> !cmd_req_o);

   // R2: the tap moves only together with the load strobe
   p_tap_moves_on_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dly_tap_o) |-> dly_load_o);

   // R7: an empty sweep leaves both delays at zero
   p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o) |-> (dly_tap_o == '0 && cmd_dly_o == '0));

   // R8: data and command delays agree once finished
   p_done_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (dly_tap_o == cmd_dly_o));

   // R8: the command delay moves only in the completion load cycle
   p_cmd_dly_settles_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cmd_dly_o) |-> (dly_load_o && !cmd_req_o));

   // R9: no command requests while done is held
   p_no_req_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !cmd_req_o);

endmodule

bind tune_dly_sweeper tune_dly_sweeper_chk #(.TAP_W(TAP_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .dly_tap_o  (dly_tap_o),
   .dly_load_o (dly_load_o),
   .cmd_req_o  (cmd_req_o),
   .cmd_dly_o  (cmd_dly_o),
   .done_o     (done_o),
   .err_o      (err_o)
);

// File: tb/tb_tune_dly_sweeper.sv
`timescale 1ns/1ps
module tb_tune_dly_sweeper;

   localparam int NT  = 128;
   localparam int BLK = 64;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       start_i = 1'b0;
   logic       cmd_done_i = 1'b0;
   logic       cmd_err_i = 1'b0;
   logic       rx_valid_i = 1'b0;
   logic [7:0] rx_data_i = 8'h00;
   logic [6:0] dly_tap_o, cmd_dly_o;
   logic       dly_load_o, cmd_req_o, done_o, err_o;

   always #2.5 clk_i = ~clk_i;

   tune_dly_sweeper dut (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .dly_tap_o  (dly_tap_o),
      .dly_load_o (dly_load_o),
      .cmd_req_o  (cmd_req_o),
      .cmd_done_i (cmd_done_i),
      .cmd_err_i  (cmd_err_i),
      .rx_valid_i (rx_valid_i),
      .rx_data_i  (rx_data_i),
      .cmd_dly_o  (cmd_dly_o),
      .done_o     (done_o),
      .err_o      (err_o)
   );

   int   n_vec = 0;
   int   n_bad = 0;
   bit   pm [NT];
   int   fk [NT];
   int   prev_sel = 0;
   bit   inject_start = 1'b0;

   function automatic logic [7:0] exp_pat(input int i);
      return 8'((i * 37) % 256) ^ 8'hA5;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Longest run, earlier on ties, floor midpoint
   task automatic model(output int sel, output bit none);
      int bl = 0, bs = 0, cl = 0, cs = 0;
      for (int i = 0; i < NT; i++) begin
         if (pm[i]) begin
            if (cl == 0) cs = i;
            cl++;
            if (cl > bl) begin bl = cl; bs = cs; end
         end else begin
            cl = 0;
         end
      end
      none = (bl == 0);
      sel  = none ? 0 : bs + (bl - 1) / 2;
   endtask

   task automatic fill_fail(input int kind);
      for (int i = 0; i < NT; i++) begin
         pm[i] = 1'b0;
         fk[i] = (kind < 0) ? int'($urandom_range(0, 3)) : kind;
      end
   endtask

   task automatic set_pass(input int lo, input int hi);
      for (int i = lo; i <= hi; i++) pm[i] = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] d);
      if ($urandom_range(0, 15) == 0) @(negedge clk_i);
      rx_valid_i = 1'b1;
      rx_data_i  = d;
      @(negedge clk_i);
      rx_valid_i = 1'b0;
   endtask

   task automatic do_trial(input int t);
      int  kind = pm[t] ? -1 : fk[t];
      int  bad_at = int'($urandom_range(0, BLK - 1));
      int  nbytes = (kind == 2) ? BLK - 1 : BLK;
      if (inject_start && t == 60) begin
         start_i = 1'b1;            // R9: stray start mid-sweep
         @(negedge clk_i);
         start_i = 1'b0;
      end
      for (int i = 0; i < nbytes; i++)
         send_byte((kind == 0 && i == bad_at) ? exp_pat(i) ^ 8'h10 : exp_pat(i));
      if (kind == 3) send_byte(exp_pat(0));
      cmd_done_i = 1'b1;
      cmd_err_i  = (kind == 1);
      @(negedge clk_i);
      cmd_done_i = 1'b0;
      cmd_err_i  = 1'b0;
   endtask

   task automatic do_sweep(input string tag);
      int sel;
      bit none;
      int guard;
      model(sel, none);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int t = 0; t < NT; t++) begin
         guard = 0;
         while (!cmd_req_o && guard < 20) begin @(negedge clk_i); guard++; end
         chk({"R2 tap order ", tag}, 32'(dly_tap_o), 32'(t));
         chk({"R8 cmd path held ", tag}, 32'(cmd_dly_o), 32'(prev_sel));
         @(negedge clk_i);
         do_trial(t);
      end
      guard = 0;
      while (!done_o && guard < 10) begin @(negedge clk_i); guard++; end
      chk({"R9 done raised ", tag}, 32'(done_o), 32'd1);
      chk({"R5 R6 chosen tap ", tag}, 32'(dly_tap_o), 32'(sel));
      chk({"R8 cmd path tap ", tag}, 32'(cmd_dly_o), 32'(sel));
      chk({"R7 error flag ", tag}, 32'(err_o), 32'(none));
      prev_sel = sel;
      repeat (3) @(negedge clk_i);
      chk({"R9 done held ", tag}, 32'(done_o), 32'd1);
      chk({"R9 no request ", tag}, 32'(cmd_req_o), 32'd0);
   endtask

   // Watchdog: a hung run counts as a failure
   initial begin
      repeat (190000) @(posedge clk_i);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk_i);
      chk("R1 done in reset", 32'(done_o), 32'd0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk("R1 done", 32'(done_o), 32'd0);
      chk("R1 err", 32'(err_o), 32'd0);
      chk("R1 req", 32'(cmd_req_o), 32'd0);
      chk("R1 load", 32'(dly_load_o), 32'd0);
      chk("R1 tap", 32'(dly_tap_o), 32'd0);
      chk("R1 cmd tap", 32'(cmd_dly_o), 32'd0);

      // R7 R4: nothing passes, mixed failure kinds
      fill_fail(-1);
      do_sweep("none");

      // R4 R3: fault bit on correct data bounds the window
      fill_fail(1); set_pass(40, 60);
      do_sweep("cmd fault");

      // R6: even-length window, short blocks elsewhere
      fill_fail(2); set_pass(20, 23); set_pass(90, 92);
      do_sweep("even run");

      // R5: equal runs keep the earlier one, long blocks elsewhere
      fill_fail(3); set_pass(10, 19); set_pass(70, 79);
      do_sweep("tie");

      // R6 R9: run to the last tap, mismatches elsewhere, stray start
      fill_fail(0); set_pass(100, 127);
      inject_start = 1'b1;
      do_sweep("top run");
      inject_start = 1'b0;

      // R5: every tap passes
      fill_fail(0); set_pass(0, NT - 1);
      do_sweep("all pass");

      // R6: lone pass at tap 0
      fill_fail(-1); set_pass(0, 0);
      do_sweep("tap zero");

      // Random windows
      for (int s = 0; s < 3; s++) begin
         int nwin = int'($urandom_range(1, 3));
         fill_fail(-1);
         for (int w = 0; w < nwin; w++) begin
            int lo = int'($urandom_range(0, NT - 1));
            int hi = lo + int'($urandom_range(0, 29));
            if (hi > NT - 1) hi = NT - 1;
            set_pass(lo, hi);
         end
         do_sweep("random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule